// File: doc/BRIEF.md
# Multifunction ALU with Result Flags

This block is the combinational integer datapath of a small load/store processor core. Two 32-bit operands enter, and a 2-bit class selector picks which of four units drives the 32-bit result: a barrel shifter, a signed set-on-less-than comparator, an adder/subtractor, or a bitwise logic unit. Further controls pick add versus subtract, one of four logic operations, one of four shift kinds, and whether the shift distance comes from a dedicated constant input or from the low bits of the x operand. The y operand is always the value that gets shifted.

Two flags go with the result. The zero flag is high whenever the selected result is all zeros. The overflow flag reports signed overflow of the adder, and it is raised only when the arithmetic class is selected. The comparator reuses the adder: selecting the comparison class forces a subtraction, and the sign of the difference, corrected by the adder's overflow, becomes bit 0 of the result.

The block has no clock, no state and no handshake. Every output settles from the current inputs, and the surrounding pipeline registers them.

Top module: `mf_alu`

## Requirements
- R1: `fn_class` selects the result source: 0 = shifter, 1 = set-less-than, 2 = adder/subtractor, 3 = logic unit.
- R2: In class 2, the result is (x + y) mod 2^32 when `sub_en` = 0 and (x - y) mod 2^32 when `sub_en` = 1.
- R3: `ovfl_flag` is high exactly when class 2 is selected and the signed two's-complement add or subtract overflows. It is 0 in classes 0, 1 and 3.
- R4: In class 3, `logic_op` selects 0 = AND, 1 = OR, 2 = XOR, 3 = NOR of x and y.
- R5: In class 0, `shift_kind` selects 0 = y unchanged, 1 = logical left, 2 = logical right, 3 = arithmetic right (sign-filled) shift of y.
- R6: The shift distance is x[4:0] when `amt_from_x` = 1 and `shamt_const` when it is 0. The unused source has no effect on the result.
- R7: In class 1, the result is 1 if x < y as signed 32-bit numbers, and 0 otherwise, with bits 31..1 always 0. The result does not depend on `sub_en`.
- R8: `zero_flag` is 1 exactly when all 32 result bits are 0, in every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | 32 | First operand; its low 5 bits can supply the shift distance |
| y_in | input | 32 | Second operand; the value that is shifted |
| fn_class | input | 2 | Result source selector |
| sub_en | input | 1 | 1 = subtract, 0 = add (class 2) |
| shift_kind | input | 2 | Shift type selector |
| amt_from_x | input | 1 | 1 = distance from x[4:0], 0 = from shamt_const |
| shamt_const | input | 5 | Constant shift distance |
| logic_op | input | 2 | Logic operation selector |
| result | output | 32 | Selected result |
| zero_flag | output | 1 | Result is all zeros |
| ovfl_flag | output | 1 | Signed overflow in the arithmetic class |

## Verification
Signed overflow is the hardest case to reach from the ports. Uniform random operands make it common for addition but rare at the exact edges, and the comparison is only wrong when overflow flips the sign of the difference. The stimulus therefore mixes uniformly random words with operands drawn from a small pool of edge values (0, 1, -1, the most positive and most negative numbers, and their neighbours). It also adds directed pairs such as most-negative minus one, evaluated in both the arithmetic and the comparison class with `sub_en` at both values.

// File: rtl/mf_alu_pkg.sv
package mf_alu_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned AMT_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    CLS_SHIFT = 2'd0,
    CLS_SLT   = 2'd1,
    CLS_ARITH = 2'd2,
    CLS_LOGIC = 2'd3
  } fn_class_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_OR  = 2'd1,
    LOP_XOR = 2'd2,
    LOP_NOR = 2'd3
  } logic_op_e;

  typedef enum logic [1:0] {
    SHK_NONE = 2'd0,
    SHK_SLL  = 2'd1,
    SHK_SRL  = 2'd2,
    SHK_SRA  = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/mf_alu_addsub.sv
module mf_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         carry_into_msb,
  output logic         carry_out
);
  logic [W:0]   cy;
  logic [W-1:0] b_eff;

  always_comb begin
    cy[0] = sub;
    for (int i = 0; i < W; i++) begin
      b_eff[i]  = b[i] ^ sub;
      sum[i]    = a[i] ^ b_eff[i] ^ cy[i];
      cy[i+1]   = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
    end
  end

  assign carry_into_msb = cy[W-1];
  assign carry_out      = cy[W];

  always_comb begin
    AST_ADDER_SUM: assert (sum == (sub ? (a - b) : (a + b)))
      else $error("adder chain result mismatch"); // R2
    AST_OVF_SIGNS: assert (!(carry_into_msb ^ carry_out) ||
                           ((a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1])))
      else $error("overflow without sign rule"); // R3
  end
endmodule

// File: rtl/mf_alu_shifter.sv
module mf_alu_shifter
  import mf_alu_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  shift_kind_e   kind,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [SW+1];
  logic         left;
  logic         fill;

  assign left     = (kind == SHK_SLL);
  assign fill     = (kind == SHK_SRA) ? din[W-1] : 1'b0;
  assign stage[0] = din;

  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int unsigned D = 1 << s;
    logic [W-1:0] shl;
    logic [W-1:0] shr;
    assign shl = {stage[s][W-1-D:0], {D{1'b0}}};
    assign shr = {{D{fill}}, stage[s][W-1:D]};
    assign stage[s+1] = !amt[s] ? stage[s] : (left ? shl : shr);
  end

  assign dout = (kind == SHK_NONE) ? din : stage[SW];

  always_comb begin
    AST_SHIFT_ZERO_AMT: assert (amt != '0 || dout == din)
      else $error("zero distance changed the value"); // R5
    AST_SHIFT_NONE: assert (kind != SHK_NONE || dout == din)
      else $error("no-shift kind changed the value"); // R5
  end
endmodule

// File: rtl/mf_alu_logic.sv
module mf_alu_logic
  import mf_alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_op_e    op,
  output logic [W-1:0] out
);
  always_comb begin
    unique case (op)
      LOP_AND: out = a & b;
      LOP_OR:  out = a | b;
      LOP_XOR: out = a ^ b;
      default: out = ~(a | b);
    endcase
  end

  always_comb begin
    AST_LOGIC_XOR_INV: assert (op != LOP_XOR || ((out ^ a) == b))
      else $error("xor not invertible"); // R4
    AST_LOGIC_NOR_DISJ: assert (op != LOP_NOR || ((out & a) == '0 && (out & b) == '0))
      else $error("nor overlaps an operand"); // R4
  end
endmodule

// File: rtl/mf_alu.sv
module mf_alu
  import mf_alu_pkg::*;
(
  input  logic [31:0] x_in,
  input  logic [31:0] y_in,
  input  logic [1:0]  fn_class,
  input  logic        sub_en,
  input  logic [1:0]  shift_kind,
  input  logic        amt_from_x,
  input  logic [4:0]  shamt_const,
  input  logic [1:0]  logic_op,
  output logic [31:0] result,
  output logic        zero_flag,
  output logic        ovfl_flag
);
  localparam int unsigned W  = DATA_W;
  localparam int unsigned SW = AMT_W;

  fn_class_e    cls;
  logic         do_sub;
  logic [W-1:0] sum;
  logic         c_in_msb;
  logic         c_out_msb;
  logic         ovf_raw;
  logic         less;
  logic [SW-1:0] amt;
  logic [W-1:0] shifted;
  logic [W-1:0] logic_res;

  assign cls    = fn_class_e'(fn_class);
  assign do_sub = sub_en | (cls == CLS_SLT);

  mf_alu_addsub #(.W(W)) u_addsub (
    .a              (x_in),
    .b              (y_in),
    .sub            (do_sub),
    .sum            (sum),
    .carry_into_msb (c_in_msb),
    .carry_out      (c_out_msb)
  );

  assign ovf_raw = c_in_msb ^ c_out_msb;
  assign less    = sum[W-1] ^ ovf_raw;

  assign amt = amt_from_x ? x_in[SW-1:0] : shamt_const;

  mf_alu_shifter #(.W(W)) u_shift (
    .din  (y_in),
    .amt  (amt),
    .kind (shift_kind_e'(shift_kind)),
    .dout (shifted)
  );

  mf_alu_logic #(.W(W)) u_logic (
    .a   (x_in),
    .b   (y_in),
    .op  (logic_op_e'(logic_op)),
    .out (logic_res)
  );

  always_comb begin
    unique case (cls)
      CLS_SHIFT: result = shifted;
      CLS_SLT:   result = {{(W-1){1'b0}}, less};
      CLS_ARITH: result = sum;
      default:   result = logic_res;
    endcase
  end

  assign zero_flag = ~|result;
  assign ovfl_flag = (cls == CLS_ARITH) & ovf_raw;

  always_comb begin
    AST_NO_OVERFLOW: assert (cls == CLS_ARITH || !ovfl_flag)
      else $error("overflow outside arithmetic class"); // R3
    AST_SLT_SHAPE: assert (cls != CLS_SLT || result[W-1:1] == '0)
      else $error("compare result has high bits"); // R7
    AST_SLT_SUBTRACTS: assert (cls != CLS_SLT || sum == x_in - y_in)
      else $error("compare did not subtract"); // R7
    AST_ZERO_IMPLIES: assert (!zero_flag || result == '0)
      else $error("zero flag with nonzero result"); // R8
  end
endmodule

// File: tb/mf_alu_tb_top.sv
module mf_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] x_in, y_in, result;
  logic [1:0]  fn_class, shift_kind, logic_op;
  logic        sub_en, amt_from_x, zero_flag, ovfl_flag;
  logic [4:0]  shamt_const;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mf_alu dut_i (
    .x_in(x_in), .y_in(y_in), .fn_class(fn_class), .sub_en(sub_en),
    .shift_kind(shift_kind), .amt_from_x(amt_from_x), .shamt_const(shamt_const),
    .logic_op(logic_op), .result(result), .zero_flag(zero_flag), .ovfl_flag(ovfl_flag)
  );

  function automatic logic [31:0] ref_res(input logic [31:0] x, input logic [31:0] y,
      input logic [1:0] c, input logic s, input logic [1:0] k, input logic ax,
      input logic [4:0] sc, input logic [1:0] lo);
    logic [4:0] d;
    d = ax ? x[4:0] : sc;
    case (c)
      2'd0: case (k)
        2'd0: return y;
        2'd1: return y << d;
        2'd2: return y >> d;
        default: return $unsigned($signed(y) >>> d);
      endcase
      2'd1: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      2'd2: return s ? x - y : x + y;
      default: case (lo)
        2'd0: return x & y;
        2'd1: return x | y;
        2'd2: return x ^ y;
        default: return ~(x | y);
      endcase
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [31:0] x, input logic [31:0] y,
      input logic [1:0] c, input logic s);
    longint sx, sy, r;
    if (c != 2'd2) return 1'b0;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    r  = s ? sx - sy : sx + sy;
    return (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [1:0] c,
      input logic s, input logic [1:0] k, input logic ax, input logic [4:0] sc,
      input logic [1:0] lo);
    logic [31:0] e;
    string tag;
    @(negedge clk);
    x_in = x; y_in = y; fn_class = c; sub_en = s; shift_kind = k;
    amt_from_x = ax; shamt_const = sc; logic_op = lo;
    @(posedge clk);
    #1;
    e = ref_res(x, y, c, s, k, ax, sc, lo);
    case (c)
      2'd0: tag = ax ? "R1/R5/R6 shift(var)" : "R1/R5/R6 shift(const)";
      2'd1: tag = "R1/R7 set-less";
      2'd2: tag = "R1/R2 add-sub";
      default: tag = "R1/R4 logic";
    endcase
    chk(tag, result, e);
    chk("R8 zero flag", {31'd0, zero_flag}, {31'd0, e == 32'd0});
    chk("R3 overflow flag", {31'd0, ovfl_flag}, {31'd0, ref_ovf(x, y, c, s)});
  endtask

  function automatic logic [31:0] pick(input int r);
    case (r % 9)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h7FFF_FFFE;
      6: return 32'h8000_0001;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    x_in = '0; y_in = '0; fn_class = 2'd3; sub_en = 0; shift_kind = 0;
    amt_from_x = 0; shamt_const = 0; logic_op = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: AND of zeros gives a zero result, zero flag set (R8)
    #1;
    chk("R8 idle result", result, 32'd0);
    chk("R8 idle zero", {31'd0, zero_flag}, 32'd1);
    // Directed edge cases
    apply(32'h7FFF_FFFF, 32'd1, 2'd2, 0, 0, 0, 0, 0);           // R3 positive overflow
    apply(32'h8000_0000, 32'd1, 2'd2, 1, 0, 0, 0, 0);           // R3 negative overflow
    apply(32'h8000_0000, 32'd1, 2'd1, 0, 0, 0, 0, 0);           // R7 sign flipped by overflow
    apply(32'h8000_0000, 32'd1, 2'd1, 1, 0, 0, 0, 0);           // R7 sub_en ignored
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'd1, 0, 0, 0, 0, 0);   // R7 max vs -1
    apply(32'd5, 32'd5, 2'd2, 1, 0, 0, 0, 0);                   // R8 zero after subtract
    apply(32'h0000_0004, 32'h8000_0000, 2'd0, 0, 2'd3, 0, 5'd31, 0); // R6 const used, x ignored
    apply(32'h0000_001F, 32'h8000_0000, 2'd0, 1, 2'd3, 1, 5'd1, 0);  // R6 var used, const ignored
    apply(32'h0000_0000, 32'h8000_0000, 2'd0, 0, 2'd2, 1, 5'd9, 0);  // R5 zero distance
    apply(32'hF0F0_F0F0, 32'hFF00_FF00, 2'd3, 0, 0, 0, 0, 2'd3);     // R4 NOR
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      apply(pick($urandom), pick($urandom), 2'($urandom), 1'($urandom),
            2'($urandom), 1'($urandom), 5'($urandom), 2'($urandom));
      if (r < 0) $display("unreachable");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule